// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small processor core and exposes it through one combinational read port and one clocked write port. Both ports are addressed by a 4-bit control-register number. The state it keeps is:

- a status byte and a backup status byte;
- a second-level backup status byte;
- a condition flag;
- two saved program counters;
- a pair of general-purpose scratch words;
- the interrupt-mode and user-mode stack pointers.

Bit 7 of the status byte selects the stack mode. The block owns the live stack pointer that the rest of the core uses as its general-register stack pointer. The stack pointer of the active mode is always the live one, and the other mode's pointer sits in a shadow register. A status write that flips the mode bit exchanges the two in the same clock edge. The core can also write the live stack pointer through a side port. If a control write touches the live pointer in the same cycle, the control write wins.

Register numbers are fixed:

| Number | Register |
|---|---|
| 0 | status |
| 1 | condition |
| 2 | interrupt stack pointer |
| 3 | user stack pointer |
| 4, 5 | scratch |
| 6 | saved PC |
| 8 | second-level backup status |
| 14 | second-level saved PC |

All other numbers are unimplemented.

Top module: `crf_bank`

## Requirements
- R1: Reading register 0 returns {backup status & 0xC1} in bits 15:8, {status & 0xC0} in bits 7:0, and the condition flag in bit 0. All other bits read as zero.
- R2: Writing register 0 loads the backup status from data bits 15:8 and the status from bits 7:0, and loads the condition flag from bit 0.
- R3: When a register 0 write changes the mode bit (status bit 7) from 0 to 1, the live stack pointer is copied into the interrupt stack pointer, and the live stack pointer takes the old user stack pointer.
- R4: When a register 0 write changes the mode bit from 1 to 0, the live stack pointer is copied into the user stack pointer, and the live stack pointer takes the old interrupt stack pointer.
- R5: Register 2 reads and writes the live stack pointer when the mode bit is 0, and its own shadow register when the bit is 1. Register 3 does the reverse.
- R6: Register 8 is written from data bits 7:0 and reads back ANDed with 0xC1.
- R7: Registers 6 and 14 store all 32 bits and read back with bit 0 forced to 0.
- R8: Register 1 reads as the condition flag in bit 0 and zero elsewhere. Writing it sets the flag from data bit 0.
- R9: Registers 4 and 5 are plain 32-bit read/write storage.
- R10: Registers 7, 9–13 and 15 read as zero, and writes to them change no register.
- R11: The side port writes the live stack pointer on the next edge, and the live stack pointer is always visible on `sp_live`.
- R12: When a control write targets the live stack pointer (including a mode swap) in the same cycle as a side-port write, the control data is kept.
- R13: Reset clears every register and leaves the mode bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 4 | Control register number to read |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Control register write strobe |
| wr_idx | input | 4 | Control register number to write |
| wr_data | input | 32 | Control register write data |
| sp_wr_en | input | 1 | Side-port write of the live stack pointer |
| sp_wr_data | input | 32 | Side-port write data |
| sp_live | output | 32 | Current live stack pointer |

## Verification
The bench builds the block with its defaults: a 32-bit data width, a 4-bit register number, and the two scratch registers at numbers 4 and 5. With that width, the mask patterns at bits 15:8 and the forced-zero bit 0 of the saved PCs can be seen directly. With a 4-bit index, every unimplemented number from 7 to 15 can be reached. Mode swaps in both directions are driven in sequence so that each shadow pointer is seen both before and after it is exchanged.

// File: rtl/crf_pkg.sv
package crf_pkg;
   localparam int unsigned IDX_W   = 4;
   localparam logic [IDX_W-1:0] CR_STAT   = 4'd0;
   localparam logic [IDX_W-1:0] CR_COND   = 4'd1;
   localparam logic [IDX_W-1:0] CR_ISP    = 4'd2;
   localparam logic [IDX_W-1:0] CR_USP    = 4'd3;
   localparam logic [IDX_W-1:0] CR_SPC    = 4'd6;
   localparam logic [IDX_W-1:0] CR_BBSTAT = 4'd8;
   localparam logic [IDX_W-1:0] CR_BBSPC  = 4'd14;
   localparam logic [7:0] STAT_RD_MASK = 8'hC0;
   localparam logic [7:0] BACK_RD_MASK = 8'hC1;
   localparam int unsigned MODE_BIT = 7;
endpackage

// File: rtl/crf_status.sv
module crf_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stat,
   input  logic       wr_cond,
   input  logic       wr_bb,
   input  logic [15:0] wr_lo,
   output logic [7:0] stat_q,
   output logic [7:0] back_q,
   output logic [7:0] bback_q,
   output logic       cond_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         back_q  <= '0;
         bback_q <= '0;
         cond_q  <= 1'b0;
      end else begin
         if (wr_stat) begin
            stat_q <= wr_lo[7:0];
            back_q <= wr_lo[15:8];
         end
         if (wr_stat || wr_cond) cond_q <= wr_lo[0];
         if (wr_bb) bback_q <= wr_lo[7:0];
      end
   end
endmodule

// File: rtl/crf_stack.sv
module crf_stack #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_q,
   input  logic          wr_stat,
   input  logic          new_mode,
   input  logic          wr_isp,
   input  logic          wr_usp,
   input  logic [DW-1:0] wr_data,
   input  logic          side_en,
   input  logic [DW-1:0] side_data,
   output logic [DW-1:0] live_q,
   output logic [DW-1:0] isp_q,
   output logic [DW-1:0] usp_q,
   output logic [DW-1:0] isp_view,
   output logic [DW-1:0] usp_view
);
   logic swap;
   logic ctl_live;

   assign swap     = wr_stat && (new_mode != mode_q);
   assign ctl_live = (wr_isp && !mode_q) || (wr_usp && mode_q);
   assign isp_view = mode_q ? isp_q : live_q;
   assign usp_view = mode_q ? live_q : usp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         isp_q  <= '0;
         usp_q  <= '0;
      end else if (swap) begin
         if (mode_q) begin
            usp_q  <= live_q;
            live_q <= isp_q;
         end else begin
            isp_q  <= live_q;
            live_q <= usp_q;
         end
      end else begin
         if (wr_isp && mode_q)  isp_q <= wr_data;
         if (wr_usp && !mode_q) usp_q <= wr_data;
         if (ctl_live)          live_q <= wr_data;
         else if (side_en)      live_q <= side_data;
      end
   end
endmodule

// File: rtl/crf_store.sv
module crf_store #(
   parameter int unsigned DW        = 32,
   parameter int unsigned SPARE_CNT = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_spc,
   input  logic                          wr_bbspc,
   input  logic [SPARE_CNT-1:0]          wr_spare,
   input  logic [DW-1:0]                 wr_data,
   output logic [DW-1:0]                 spc_q,
   output logic [DW-1:0]                 bbspc_q,
   output logic [SPARE_CNT-1:0][DW-1:0]  spare_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spc_q   <= '0;
         bbspc_q <= '0;
      end else begin
         if (wr_spc)   spc_q   <= wr_data;
         if (wr_bbspc) bbspc_q <= wr_data;
      end
   end

   for (genvar g = 0; g < SPARE_CNT; g++) begin : g_spare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          spare_q[g] <= '0;
         else if (wr_spare[g]) spare_q[g] <= wr_data;
      end
   end
endmodule

// File: rtl/crf_bank.sv
module crf_bank
   import crf_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned SPARE_BASE = 4,
   parameter int unsigned SPARE_CNT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DW-1:0]    rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic             sp_wr_en,
   input  logic [DW-1:0]    sp_wr_data,
   output logic [DW-1:0]    sp_live
);
   localparam int unsigned SPARE_END = SPARE_BASE + SPARE_CNT;
   localparam logic [DW-1:0] PC_MASK = {{(DW-1){1'b1}}, 1'b0};

   initial begin
      if (DW < 16) $error("crf_bank: DW must be at least 16");
      if (SPARE_CNT < 1) $error("crf_bank: SPARE_CNT must be at least 1");
      if (SPARE_END > 6) $error("crf_bank: scratch registers overlap fixed numbers");
   end

   logic [7:0]  stat_q, back_q, bback_q;
   logic        cond_q, mode_q;
   logic [DW-1:0] isp_q, usp_q, isp_view, usp_view, spc_q, bbspc_q;
   logic [SPARE_CNT-1:0][DW-1:0] spare_q;
   logic [SPARE_CNT-1:0] wr_spare;

   logic wr_stat, wr_cond, wr_bb, wr_isp, wr_usp, wr_spc, wr_bbspc;
   assign wr_stat  = wr_en && (wr_idx == CR_STAT);
   assign wr_cond  = wr_en && (wr_idx == CR_COND);
   assign wr_bb    = wr_en && (wr_idx == CR_BBSTAT);
   assign wr_isp   = wr_en && (wr_idx == CR_ISP);
   assign wr_usp   = wr_en && (wr_idx == CR_USP);
   assign wr_spc   = wr_en && (wr_idx == CR_SPC);
   assign wr_bbspc = wr_en && (wr_idx == CR_BBSPC);

   for (genvar g = 0; g < SPARE_CNT; g++) begin : g_wsel
      assign wr_spare[g] = wr_en && (int'(wr_idx) == SPARE_BASE + g);
   end

   assign mode_q = stat_q[MODE_BIT];

   crf_status u_status (
      .clk(clk), .rst_n(rst_n),
      .wr_stat(wr_stat), .wr_cond(wr_cond), .wr_bb(wr_bb),
      .wr_lo(wr_data[15:0]),
      .stat_q(stat_q), .back_q(back_q), .bback_q(bback_q), .cond_q(cond_q)
   );

   crf_stack #(.DW(DW)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .mode_q(mode_q), .wr_stat(wr_stat), .new_mode(wr_data[MODE_BIT]),
      .wr_isp(wr_isp), .wr_usp(wr_usp), .wr_data(wr_data),
      .side_en(sp_wr_en), .side_data(sp_wr_data),
      .live_q(sp_live), .isp_q(isp_q), .usp_q(usp_q),
      .isp_view(isp_view), .usp_view(usp_view)
   );

   crf_store #(.DW(DW), .SPARE_CNT(SPARE_CNT)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_spc(wr_spc), .wr_bbspc(wr_bbspc), .wr_spare(wr_spare),
      .wr_data(wr_data),
      .spc_q(spc_q), .bbspc_q(bbspc_q), .spare_q(spare_q)
   );

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         CR_STAT:   rd_data[15:0] = {back_q & BACK_RD_MASK,
                                     (stat_q & STAT_RD_MASK) | {7'd0, cond_q}};
         CR_COND:   rd_data[0]    = cond_q;
         CR_ISP:    rd_data       = isp_view;
         CR_USP:    rd_data       = usp_view;
         CR_SPC:    rd_data       = spc_q & PC_MASK;
         CR_BBSPC:  rd_data       = bbspc_q & PC_MASK;
         CR_BBSTAT: rd_data[7:0]  = bback_q & BACK_RD_MASK;
         default: begin
            for (int i = 0; i < SPARE_CNT; i++)
               if (int'(rd_idx) == SPARE_BASE + i) rd_data = spare_q[i];
         end
      endcase
   end
endmodule

// File: rtl/crf_bank_chk.sv
module crf_bank_chk
   import crf_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned SPARE_BASE = 4,
   parameter int unsigned SPARE_CNT  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] rd_idx,
   input logic [DW-1:0]    rd_data,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [DW-1:0]    wr_data,
   input logic             sp_wr_en,
   input logic [DW-1:0]    sp_wr_data,
   input logic [DW-1:0]    sp_live,
   input logic             mode_q,
   input logic [DW-1:0]    isp_q,
   input logic [DW-1:0]    usp_q
);
   localparam logic [DW-1:0] STAT_ZERO = ~{{(DW-16){1'b0}}, 16'hC1C1};

   logic rd_impl;
   always_comb begin
      rd_impl = (rd_idx == CR_STAT) || (rd_idx == CR_COND) || (rd_idx == CR_ISP) ||
                (rd_idx == CR_USP) || (rd_idx == CR_SPC) || (rd_idx == CR_BBSTAT) ||
                (rd_idx == CR_BBSPC) ||
                ((int'(rd_idx) >= SPARE_BASE) && (int'(rd_idx) < SPARE_BASE + SPARE_CNT));
   end

   AST_STAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == CR_STAT) |-> ((rd_data & STAT_ZERO) == '0)); // R1
   AST_SWAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == CR_STAT && !mode_q && wr_data[MODE_BIT])
      |=> (sp_live == $past(usp_q)) && (isp_q == $past(sp_live))); // R3
   AST_SWAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == CR_STAT && mode_q && !wr_data[MODE_BIT])
      |=> (sp_live == $past(isp_q)) && (usp_q == $past(sp_live))); // R4
   AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == CR_SPC || rd_idx == CR_BBSPC) |-> (rd_data[0] == 1'b0)); // R7
   AST_COND_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == CR_COND) |-> (rd_data[DW-1:1] == '0)); // R8
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_impl |-> (rd_data == '0)); // R10
   AST_SIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && !wr_en) |=> (sp_live == $past(sp_wr_data))); // R11
   AST_CTL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && wr_en && ((wr_idx == CR_ISP && !mode_q) || (wr_idx == CR_USP && mode_q)))
      |=> (sp_live == $past(wr_data))); // R12
endmodule

bind crf_bank crf_bank_chk #(.DW(DW), .SPARE_BASE(SPARE_BASE), .SPARE_CNT(SPARE_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_live(sp_live),
   .mode_q(mode_q), .isp_q(isp_q), .usp_q(usp_q)
);

// File: tb/crf_bank_bench.sv
`timescale 1ns/1ps
module crf_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        sp_wr_en = 1'b0;
   logic [31:0] sp_wr_data = '0;
   logic [31:0] sp_live;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   crf_bank u_crf_bank (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_live(sp_live)
   );

   // {write number, write data, read number, expected read data}
   localparam int NV = 16;
   localparam logic [71:0] VEC [NV] = '{
      {4'd4,  32'h1234_5678, 4'd4,  32'h1234_5678},  // R9
      {4'd5,  32'hDEAD_BEEF, 4'd5,  32'hDEAD_BEEF},  // R9
      {4'd6,  32'h0000_1235, 4'd6,  32'h0000_1234},  // R7
      {4'd14, 32'hFFFF_FFFF, 4'd14, 32'hFFFF_FFFE},  // R7
      {4'd8,  32'hFFFF_FFFF, 4'd8,  32'h0000_00C1},  // R6
      {4'd2,  32'h0000_1000, 4'd2,  32'h0000_1000},  // R5 live
      {4'd3,  32'h0000_2000, 4'd3,  32'h0000_2000},  // R5 shadow
      {4'd0,  32'h0000_FF81, 4'd0,  32'h0000_C181},  // R1 R2 R3
      {4'd7,  32'hFFFF_FFFF, 4'd2,  32'h0000_1000},  // R3 R10
      {4'd9,  32'hFFFF_FFFF, 4'd3,  32'h0000_2000},  // R3 R5 R10
      {4'd1,  32'h0000_0000, 4'd0,  32'h0000_C180},  // R8
      {4'd3,  32'h0000_3000, 4'd2,  32'h0000_1000},  // R5
      {4'd0,  32'h0000_0040, 4'd3,  32'h0000_3000},  // R4
      {4'd15, 32'h0000_AAAA, 4'd2,  32'h0000_1000},  // R4 R10
      {4'd1,  32'hFFFF_FFFF, 4'd1,  32'h0000_0001},  // R8
      {4'd0,  32'h0000_3E3E, 4'd0,  32'h0000_0000}   // R1 R2
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cwrite(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13: reset state
      rd_idx = 4'd0; #1 check("R13", rd_data, 32'h0);
      check("R13", sp_live, 32'h0);
      rd_idx = 4'd4; #1 check("R13", rd_data, 32'h0);

      for (int i = 0; i < NV; i++) begin
         cwrite(VEC[i][71:68], VEC[i][67:36]);
         rd_idx = VEC[i][35:32];
         #1 check($sformatf("table row %0d", i), rd_data, VEC[i][31:0]);
      end
      // after the table: mode 0, live = 0x1000, user shadow = 0x3000
      check("R11", sp_live, 32'h0000_1000);

      // R11: side-port write alone
      @(negedge clk); sp_wr_en = 1'b1; sp_wr_data = 32'h0000_5555;
      @(negedge clk); sp_wr_en = 1'b0;
      check("R11", sp_live, 32'h0000_5555);
      rd_idx = 4'd2; #1 check("R11", rd_data, 32'h0000_5555);

      // R12: control write to the live pointer collides with the side port
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h0000_7777;
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_8888;
      @(negedge clk); wr_en = 1'b0; sp_wr_en = 1'b0;
      check("R12", sp_live, 32'h0000_7777);

      // R11: control write elsewhere does not block the side port
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'h0000_0001;
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_9999;
      @(negedge clk); wr_en = 1'b0; sp_wr_en = 1'b0;
      check("R11", sp_live, 32'h0000_9999);
      rd_idx = 4'd4; #1 check("R9", rd_data, 32'h0000_0001);

      // R12: a mode swap beats the side port; live takes user shadow 0x3000
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h0000_0080;
      sp_wr_en = 1'b1; sp_wr_data = 32'h0000_AAAA;
      @(negedge clk); wr_en = 1'b0; sp_wr_en = 1'b0;
      check("R12", sp_live, 32'h0000_3000);
      rd_idx = 4'd2; #1 check("R3", rd_data, 32'h0000_9999);

      // R10: a write to register 12 changes nothing readable
      cwrite(4'd12, 32'hFFFF_FFFF);
      rd_idx = 4'd12; #1 check("R10", rd_data, 32'h0);
      rd_idx = 4'd0;  #1 check("R10", rd_data, 32'h0000_0080);
      check("R10", sp_live, 32'h0000_3000);

      // R13: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_idx = 4'd5; #1 check("R13", rd_data, 32'h0);
      check("R13", sp_live, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule